// File: doc/BRIEF.md
# Serial Frame Transfer Engine

This block runs one transaction on a simple synchronous serial bus. When the host side pulses `start` while the engine is idle, it takes a 16-bit word made of an upper and a lower byte. It shifts the word out on `sout` against a shift clock `sclk` that it makes itself. In the same frame it captures a 9-bit answer from `sin`. The active-low `oe_n` marks the frame on the wire. The engine reports progress through `busy` and a one-cycle `done` pulse. Interrupt logic can hang off `done`.

The shift clock comes from the system clock through a divider with four settings. The divider code, the word and the frame timing are latched when a frame starts. Later changes on those inputs only affect the next frame. The first captured bit is the slave's acknowledge and is kept on its own. The next eight captured bits form the received byte. Outside a frame, `sclk`, `sout` and `oe_n` all stay high.

Top module: `serial_frame_engine`

## Requirements
- R1: After a synchronous reset, `sclk`, `sout` and `oe_n` are 1, `busy` and `done` are 0, `ack` is 1, `rx_data` is 0, and the divider code resets to /2.
- R2: A `start` seen while idle sets `busy` to 1 and `oe_n` to 0 at the next clock edge. `sclk` stays high at that point.
- R3: With H = 2^`div_sel`, `sclk` falls H system clocks after the accepting edge and then toggles every H clocks. Its period is 2 (code 00), 4 (01), 8 (10) or 16 (11) system clocks. There are exactly 16 falling and 16 rising edges per frame.
- R4: `sout` changes only together with a falling edge of `sclk`. It presents `tx_hi` bit 7 down to bit 0, then `tx_lo` bit 7 down to bit 0.
- R5: `sin` is sampled at the clock edge where `sclk` rises. The sample at rising edge 8 becomes `ack`. The samples at rising edges 9 to 16 enter `rx_data` most significant bit first, so the sample from edge 16 ends up in bit 0.
- R6: One shift-clock period (2H clocks) after rising edge 16, `busy` drops to 0 and `oe_n` and `sout` return to 1, all at the same edge. `busy` is high for exactly 34·H clocks.
- R7: `done` is 1 for exactly one clock, in the cycle right after `busy` falls, and is otherwise 0.
- R8: `div_sel`, `tx_hi` and `tx_lo` are latched at the accepting edge. Changing them during a frame affects neither its timing nor its data.
- R9: A `start` pulse while `busy` is 1 is ignored. The frame in progress keeps its length and data.
- R10: A `start` in the cycle where `done` is 1 is accepted, so frames can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch request, acted on only when idle |
| div_sel | input | 2 | Shift clock divider code (00 /2, 01 /4, 10 /8, 11 /16) |
| tx_hi | input | 8 | Upper byte, sent first |
| tx_lo | input | 8 | Lower byte, sent second |
| sin | input | 1 | Serial data from the bus |
| sclk | output | 1 | Shift clock, high when idle |
| sout | output | 1 | Serial data to the bus, high when idle |
| oe_n | output | 1 | Active-low frame enable |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| ack | output | 1 | Captured acknowledge bit |
| rx_data | output | 8 | Captured data byte |

## Verification
The close of one frame and the launch of the next can coincide. `done` is high in the very cycle where a new `start` is accepted. The bench provokes this by issuing `start` at the first sample after `busy` drops. It then judges that the `done` pulse still lasts one cycle, that `busy` rises again at the next edge, and that the new frame's clock and data follow its own latched settings. A second collision is also driven: a `start` pulse in mid-frame, together with changes on `div_sel` and the data bytes. A cycle-accurate model is compared on every clock, and the measured frame length must stay 34·H.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    localparam int unsigned SFE_BYTE_W = 8;
    localparam int unsigned SFE_SEL_W  = 2;

    typedef enum logic [SFE_SEL_W-1:0] {
        DIV_2  = 2'd0,
        DIV_4  = 2'd1,
        DIV_8  = 2'd2,
        DIV_16 = 2'd3
    } div_code_t;

    // events raised by the sequencer on one divider tick
    typedef struct packed {
        logic fall;
        logic rise;
        logic take_ack;
        logic take_dat;
        logic fin;
    } sfe_evt_t;

    // half of the shift clock period, in system clocks
    function automatic int unsigned half_period(div_code_t c);
        return 32'd1 << c;
    endfunction

endpackage

// File: rtl/sfe_clkdiv.sv
module sfe_clkdiv
    import sfe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      stop,
    input  div_code_t sel,
    output logic      tick
);
    localparam int unsigned CNT_W = (1 << SFE_SEL_W) - 1;

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    div_code_t        sel_q;

    assign tick = run_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            sel_q <= DIV_2;
        end else if (load) begin
            run_q <= 1'b1;
            sel_q <= sel;
            cnt_q <= CNT_W'(half_period(sel) - 1);
        end else if (stop) begin
            run_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= CNT_W'(half_period(sel_q) - 1);
        end else if (run_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R8: the latched code holds for the whole run
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && !load) |=> (sel_q == $past(sel_q)));

endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              shift,
    input  logic              release_line,
    output logic              sout
);
    logic [WORD_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
            sout <= 1'b1;
        end else if (load) begin
            sr_q <= word;
        end else if (shift) begin
            sout <= sr_q[WORD_W-1];
            sr_q <= {sr_q[WORD_W-2:0], 1'b0};
        end else if (release_line) begin
            sout <= 1'b1;
        end
    end

    // R4: the line only moves on a shift or on release
    sout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift && !release_line) |=> $stable(sout));

endmodule

// File: rtl/sfe_capture.sv
module sfe_capture #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sin,
    input  logic              take_ack,
    input  logic              take_dat,
    output logic              ack,
    output logic [BYTE_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ack  <= 1'b1;
            data <= '0;
        end else begin
            if (take_ack) ack <= sin;
            if (take_dat) data <= {data[BYTE_W-2:0], sin};
        end
    end

    // R5: acknowledge and data capture never share an edge
    ack_dat_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(take_ack && take_dat));

endmodule

// File: rtl/serial_frame_engine.sv
module serial_frame_engine
    import sfe_pkg::*;
#(
    parameter int unsigned BYTE_W = SFE_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        div_sel,
    input  logic [BYTE_W-1:0] tx_hi,
    input  logic [BYTE_W-1:0] tx_lo,
    input  logic              sin,
    output logic              sclk,
    output logic              sout,
    output logic              oe_n,
    output logic              busy,
    output logic              done,
    output logic              ack,
    output logic [BYTE_W-1:0] rx_data
);
    localparam int unsigned FRAME_W   = 2 * BYTE_W;
    localparam int unsigned EDGES     = 2 * FRAME_W;
    localparam int unsigned STEP_W    = $clog2(EDGES + 2);
    localparam logic [STEP_W-1:0] EDGE_END  = STEP_W'(EDGES);
    localparam logic [STEP_W-1:0] STEP_FIN  = STEP_W'(EDGES + 1);
    localparam logic [STEP_W-1:0] STEP_ACK  = STEP_W'(2 * BYTE_W - 1);

    logic              busy_q, oe_q, sclk_q, done_q;
    logic [STEP_W-1:0] step_q;
    logic              tick, accept;
    sfe_evt_t          ev;

    assign accept = start && !busy_q;

    always_comb begin
        ev.fall     = tick && (step_q < EDGE_END) && !step_q[0];
        ev.rise     = tick && (step_q < EDGE_END) &&  step_q[0];
        ev.take_ack = ev.rise && (step_q == STEP_ACK);
        ev.take_dat = ev.rise && (step_q >  STEP_ACK);
        ev.fin      = tick && (step_q == STEP_FIN);
    end

    sfe_clkdiv u_div (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .stop (ev.fin),
        .sel  (div_code_t'(div_sel)),
        .tick (tick)
    );

    sfe_shifter #(.WORD_W(FRAME_W)) u_tx (
        .clk          (clk),
        .rst          (rst),
        .load         (accept),
        .word         ({tx_hi, tx_lo}),
        .shift        (ev.fall),
        .release_line (ev.fin),
        .sout         (sout)
    );

    sfe_capture #(.BYTE_W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .sin      (sin),
        .take_ack (ev.take_ack),
        .take_dat (ev.take_dat),
        .ack      (ack),
        .data     (rx_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            oe_q   <= 1'b1;
            sclk_q <= 1'b1;
            done_q <= 1'b0;
            step_q <= '0;
        end else begin
            done_q <= ev.fin;
            if (accept) begin
                busy_q <= 1'b1;
                oe_q   <= 1'b0;
                step_q <= '0;
            end else if (tick) begin
                step_q <= step_q + 1'b1;
                if (ev.fall) sclk_q <= 1'b0;
                if (ev.rise) sclk_q <= 1'b1;
                if (ev.fin) begin
                    busy_q <= 1'b0;
                    oe_q   <= 1'b1;
                end
            end
        end
    end

    assign sclk = sclk_q;
    assign oe_n = oe_q;
    assign busy = busy_q;
    assign done = done_q;

    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (sclk_q && sout && oe_q));

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_q) |=> (busy_q && !oe_q && sclk_q));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!busy_q && $past(busy_q)));

    // R9
    hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !ev.fin) |=> busy_q);

    // R3
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !sclk_q |-> !oe_q);

endmodule

// File: tb/serial_frame_engine_bench.sv
module serial_frame_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic [7:0] tx_hi = 8'h00, tx_lo = 8'h00;
    logic       sin;
    logic       sclk, sout, oe_n, busy, done, ack;
    logic [7:0] rx_data;
    logic [15:0] lfsr = 16'hACE1;

    int vectors = 0;
    int fails = 0;

    // reference model state
    bit        mbusy = 0, moe = 1, msclk = 1, msout = 1, mack = 1, mdone = 0;
    bit [7:0]  mrx = 0;
    bit [15:0] mword = 0;
    int        me = 0, mh = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sin = lfsr[0];

    serial_frame_engine u_serial_frame_engine (
        .clk(clk), .rst(rst), .start(start), .div_sel(div_sel),
        .tx_hi(tx_hi), .tx_lo(tx_lo), .sin(sin),
        .sclk(sclk), .sout(sout), .oe_n(oe_n), .busy(busy),
        .done(done), .ack(ack), .rx_data(rx_data)
    );

    task automatic chk(input string tag, input int got, input int exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // behavioural reference, advanced at each rising clock edge
    always @(posedge clk) begin
        mdone = 0;
        if (rst) begin
            mbusy = 0; moe = 1; msclk = 1; msout = 1; mack = 1; mrx = 0;
        end else if (mbusy) begin
            me++;
            if (me % mh == 0) begin
                int t;
                t = me / mh;
                if (t <= 2*FW) begin
                    if (t % 2 == 1) begin
                        msclk = 0;
                        msout = mword[FW - (t+1)/2];
                    end else begin
                        msclk = 1;
                        if (t/2 == 8) mack = sin;
                        else if (t/2 > 8) mrx = {mrx[6:0], sin};
                    end
                end else if (t == 2*FW + 2) begin
                    mbusy = 0; moe = 1; msout = 1; mdone = 1;
                end
            end
        end else if (start) begin
            mbusy = 1; moe = 0; me = 0;
            mh = 1 << div_sel;
            mword = {tx_hi, tx_lo};
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        lfsr <= {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        if (!rst) begin
            chk("R3 sclk", sclk, msclk);
            chk("R4 sout", sout, msout);
            chk("R6 oe_n", oe_n, moe);
            chk("R6 busy", busy, mbusy);
            chk("R7 done", done, mdone);
            chk("R5 ack", ack, mack);
            chk("R5 rx_data", rx_data, mrx);
        end
    end

    task automatic frame(input [7:0] hi, input [7:0] lo, input [1:0] sel,
                         input [1:0] sel_mid, input bit poke, input bit chained);
        int len;
        if (chained) chk("R10 done high when restarting", done, 1);
        tx_hi = hi; tx_lo = lo; div_sel = sel; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", busy, 1);
        chk("R2 oe_n after start", oe_n, 0);
        len = 0;
        while (busy === 1'b1 && len < 2000) begin
            len++;
            if (len == 5) begin
                div_sel = sel_mid; tx_hi = ~hi; tx_lo = ~lo;
                if (poke) start = 1'b1;
            end
            if (len == 6) start = 1'b0;
            @(negedge clk);
        end
        // R6 R8 R9: length follows the latched code only
        chk("R6 frame length", len, 34 << sel);
        chk("R7 done at frame end", done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sclk", sclk, 1);
        chk("R1 sout", sout, 1);
        chk("R1 oe_n", oe_n, 1);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 ack", ack, 1);
        chk("R1 rx_data", rx_data, 0);
        repeat (3) @(negedge clk);
        frame(8'hA5, 8'h3C, 2'd0, 2'd0, 0, 0);
        repeat (4) @(negedge clk);
        frame(8'hF0, 8'h0F, 2'd1, 2'd1, 0, 0);
        frame(8'h81, 8'h7E, 2'd2, 2'd2, 0, 1);   // R10 back to back
        repeat (2) @(negedge clk);
        frame(8'hC3, 8'h5A, 2'd3, 2'd0, 0, 0);   // R8 code change mid-frame
        repeat (2) @(negedge clk);
        frame(8'h12, 8'h34, 2'd1, 2'd3, 1, 0);   // R9 start while busy
        frame(8'hFF, 8'h00, 2'd0, 2'd2, 1, 1);   // R9 R10 combined
        repeat (3) @(negedge clk);
        chk("R1 idle sclk after frames", sclk, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule